// File: doc/BRIEF.md
# Delta Bit-Plane XOR Transform

This block prepares a 128-byte cache line for a pattern-based compressor. It accepts the whole line at once as 32 words of 32 bits. It subtracts each word from the word that follows it and regroups the resulting differences by bit position, giving one plane per bit position. It then chains neighbouring planes through XOR so that constant strides, high-order zeros and alternating-sign differences become all-zero words, which a downstream encoder can code cheaply.

Word 0 is not differenced. It leaves the block unchanged as the base value. The planes leave one per cycle over a valid/ready stream, from the most significant bit position down to bit 0. Each plane carries its index, a last marker, and a flag that says whether the plane was already zero before the XOR step. The encoder uses that flag to pick a zero code where one applies.

Top module: `bpx_transform`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1 until a line is accepted.
- R2: `out_base` equals word 0 of the accepted line (bits 31:0 of `in_line`). It holds that value for every plane of that line.
- R3: Delta j (j = 0..30) is word j+1 minus word j, taken modulo 2^32. Word j sits at `in_line[32*j+31 : 32*j]`. Bit j of untransformed plane i is bit i of delta j.
- R4: The 32 planes of a line are emitted in order from index 31 down to index 0, one per output handshake. The current plane's index appears on `out_idx`.
- R5: The plane with index 31 is emitted untransformed. Every other plane i is emitted as untransformed plane i XOR untransformed plane i+1.
- R6: `out_zero` is 1 exactly when the untransformed plane with the current index is all zeros.
- R7: `out_last` is 1 only on the plane with index 0.
- R8: `in_ready` is 0 whenever `out_valid` is 1. It returns to 1 in the cycle that follows the handshake of plane 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` at 1 with the same plane, index, flags and base.
- R10: `in_valid` raised while a line is still streaming has no effect. The streamed planes and the base stay those of the line already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A line is offered on `in_line` |
| in_ready | output | 1 | The block can accept a line |
| in_line | input | 1024 | 32 words of 32 bits; word j at bits 32*j+31:32*j |
| out_valid | output | 1 | A plane is presented |
| out_ready | input | 1 | The consumer takes the presented plane |
| out_base | output | 32 | Word 0 of the current line |
| out_plane | output | 31 | Plane after the XOR chain |
| out_zero | output | 1 | Untransformed plane was all zeros |
| out_idx | output | 5 | Bit position of the presented plane |
| out_last | output | 1 | Marks the plane with index 0 |

## Verification
The bench builds the block with its default geometry of 32 words of 32 bits. This is the full line width, so every plane index from 31 down to 0, the modulo wrap of descending word sequences and the full 31-bit plane width are all exercised. Traffic includes constant strides, alternating-sign steps, an all-zero line, a single outlier word and random lines. These make all-ones planes, zero planes, and planes that are non-zero before the XOR but zero after it. A randomly throttled `out_ready` together with line offers made while a line is still streaming covers the stall and ignore behaviour.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

  // default geometry: a 128-byte line of 32-bit words
  localparam int unsigned DEF_NUM_WORDS = 32;
  localparam int unsigned DEF_WORD_BITS = 32;

  // sequencer states
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } bpx_state_e;

endpackage

// File: rtl/bpx_delta.sv
module bpx_delta #(
  parameter int unsigned NUM_WORDS = 32,
  parameter int unsigned WORD_BITS = 32,
  localparam int unsigned LINE_BITS = NUM_WORDS * WORD_BITS,
  localparam int unsigned NUM_DELTA = NUM_WORDS - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [LINE_BITS-1:0] line_i,
  output logic [WORD_BITS-1:0] base_o,
  output logic [WORD_BITS-1:0] delta_o [NUM_DELTA]
);

  logic [WORD_BITS-1:0] base_d;
  logic [WORD_BITS-1:0] delta_d [NUM_DELTA];
  logic [WORD_BITS-1:0] base_q;
  logic [WORD_BITS-1:0] delta_q [NUM_DELTA];

  // next-state: differences of neighbouring words, modulo 2^WORD_BITS
  always_comb begin
    base_d = line_i[WORD_BITS-1:0];
  end

  for (genvar j = 0; j < NUM_DELTA; j++) begin : g_diff
    always_comb begin
      delta_d[j] = line_i[(j+1)*WORD_BITS +: WORD_BITS]
                 - line_i[j*WORD_BITS +: WORD_BITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        delta_q[j] <= '0;
      end else if (load_en) begin
        delta_q[j] <= delta_d[j];
      end
    end

    assign delta_o[j] = delta_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (load_en) begin
      base_q <= base_d;
    end
  end

  assign base_o = base_q;

endmodule

// File: rtl/bpx_plane_sel.sv
module bpx_plane_sel #(
  parameter int unsigned NUM_WORDS = 32,
  parameter int unsigned WORD_BITS = 32,
  localparam int unsigned NUM_DELTA = NUM_WORDS - 1,
  localparam int unsigned IDX_BITS  = $clog2(WORD_BITS)
) (
  input  logic [WORD_BITS-1:0] delta_i [NUM_DELTA],
  input  logic [IDX_BITS-1:0]  sel_i,
  output logic [NUM_DELTA-1:0] plane_o,
  output logic                 zero_o
);

  localparam logic [IDX_BITS-1:0] TOP_IDX = IDX_BITS'(WORD_BITS - 1);

  logic [IDX_BITS-1:0]  sel_up;
  logic                 at_top;
  logic [NUM_DELTA-1:0] raw_cur;
  logic [NUM_DELTA-1:0] raw_up;

  always_comb begin
    sel_up = sel_i + 1'b1;
    at_top = (sel_i == TOP_IDX);
  end

  // transpose: bit j of a plane comes from delta j at the selected position
  for (genvar j = 0; j < NUM_DELTA; j++) begin : g_col
    always_comb begin
      raw_cur[j] = delta_i[j][sel_i];
      raw_up[j]  = at_top ? 1'b0 : delta_i[j][sel_up];
    end
  end

  // XOR chain with the plane one position higher; the top plane passes through
  always_comb begin
    plane_o = raw_cur ^ raw_up;
    zero_o  = (raw_cur == '0);
  end

endmodule

// File: rtl/bpx_seq.sv
module bpx_seq
  import bpx_pkg::*;
#(
  parameter int unsigned WORD_BITS = 32,
  localparam int unsigned IDX_BITS = $clog2(WORD_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  output logic                load_en_o,
  input  logic                out_ready_i,
  output logic                out_valid_o,
  output logic [IDX_BITS-1:0] idx_o,
  output logic                last_o
);

  localparam logic [IDX_BITS-1:0] TOP_IDX = IDX_BITS'(WORD_BITS - 1);

  bpx_state_e          state_q, state_d;
  logic [IDX_BITS-1:0] cnt_q, cnt_d;
  logic                cnt_en;

  // next-state
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    in_ready_o = 1'b0;
    load_en_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          load_en_o = 1'b1;
          state_d   = ST_SEND;
          cnt_d     = TOP_IDX;
          cnt_en    = 1'b1;
        end
      end
      ST_SEND: begin
        if (out_ready_i) begin
          if (cnt_q == '0) begin
            state_d = ST_IDLE;
          end else begin
            cnt_d  = cnt_q - 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign out_valid_o = (state_q == ST_SEND);
  assign idx_o       = cnt_q;
  assign last_o      = (state_q == ST_SEND) && (cnt_q == '0);

  // R8: input and output never open at once
  p_in_out_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready_o && out_valid_o));

  // R8: after plane 0 is handed off, a new line can be taken
  p_ready_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && last_o) |=> in_ready_o);

  // R4: a line starts at the top plane
  p_start_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_o |=> (out_valid_o && idx_o == TOP_IDX));

  // R4: each handshake steps the index down by one
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !last_o) |=>
      (out_valid_o && idx_o == $past(idx_o) - 1'b1));

  // R9: a stalled plane stays presented
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(idx_o)));

endmodule

// File: rtl/bpx_transform.sv
module bpx_transform
  import bpx_pkg::*;
#(
  parameter int unsigned NUM_WORDS = DEF_NUM_WORDS,
  parameter int unsigned WORD_BITS = DEF_WORD_BITS,
  localparam int unsigned LINE_BITS = NUM_WORDS * WORD_BITS,
  localparam int unsigned NUM_DELTA = NUM_WORDS - 1,
  localparam int unsigned IDX_BITS  = $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LINE_BITS-1:0] in_line,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_BITS-1:0] out_base,
  output logic [NUM_DELTA-1:0] out_plane,
  output logic                 out_zero,
  output logic [IDX_BITS-1:0]  out_idx,
  output logic                 out_last
);

  logic                 load_en;
  logic [WORD_BITS-1:0] delta [NUM_DELTA];

  bpx_seq #(
    .WORD_BITS (WORD_BITS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .load_en_o   (load_en),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .idx_o       (out_idx),
    .last_o      (out_last)
  );

  bpx_delta #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_BITS (WORD_BITS)
  ) u_delta (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .line_i  (in_line),
    .base_o  (out_base),
    .delta_o (delta)
  );

  bpx_plane_sel #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_BITS (WORD_BITS)
  ) u_sel (
    .delta_i (delta),
    .sel_i   (out_idx),
    .plane_o (out_plane),
    .zero_o  (out_zero)
  );

  // R9: the whole presented item holds under back-pressure
  p_stall_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      ($stable(out_plane) && $stable(out_zero) && $stable(out_base)));

  // R10: offers during streaming leave the stored line untouched
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_valid) |=> ($stable(out_base) && out_valid == $past(!out_last || !out_ready)));

  // R2: base holds across consecutive planes of a line
  p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> $stable(out_base));

  // R7: last is only ever seen with a presented plane
  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

endmodule

// File: tb/bpx_transform_tb_top.sv
module bpx_transform_tb_top;

  localparam int unsigned NW   = 32;
  localparam int unsigned WB   = 32;
  localparam int unsigned LB   = NW * WB;
  localparam int unsigned ND   = NW - 1;
  localparam int unsigned IB   = $clog2(WB);
  localparam int unsigned WDOG = 20000;

  typedef struct packed {
    logic [WB-1:0] base;
    logic [ND-1:0] plane;
    logic          zero;
    logic [IB-1:0] idx;
    logic          last;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [LB-1:0] in_line;
  logic          out_valid;
  logic          out_ready;
  logic [WB-1:0] out_base;
  logic [ND-1:0] out_plane;
  logic          out_zero;
  logic [IB-1:0] out_idx;
  logic          out_last;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  bit   throttle = 1'b0;
  item_t exp_q [$];

  always #2.5 clk = ~clk;

  bpx_transform #(.NUM_WORDS(NW), .WORD_BITS(WB)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_line   (in_line),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_base  (out_base),
    .out_plane (out_plane),
    .out_zero  (out_zero),
    .out_idx   (out_idx),
    .out_last  (out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected items for one line, from the requirements
  task automatic push_expected(input logic [LB-1:0] ln);
    logic [WB-1:0] d [ND];
    logic [ND-1:0] raw [WB];
    item_t it;
    for (int j = 0; j < ND; j++) begin
      d[j] = ln[(j+1)*WB +: WB] - ln[j*WB +: WB];
    end
    for (int i = 0; i < WB; i++) begin
      for (int j = 0; j < ND; j++) raw[i][j] = d[j][i];
    end
    for (int i = WB - 1; i >= 0; i--) begin
      it.base  = ln[WB-1:0];
      it.plane = (i == WB - 1) ? raw[i] : (raw[i] ^ raw[i+1]);
      it.zero  = (raw[i] == '0);
      it.idx   = IB'(i);
      it.last  = (i == 0);
      exp_q.push_back(it);
    end
  endtask

  task automatic send_line(input logic [LB-1:0] ln, input bit poke);
    push_expected(ln);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_line  = ln;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    if (poke) begin
      // R10: keep offering a different line while this one streams
      in_line = ~ln;
      repeat (4) @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  function automatic logic [LB-1:0] mk_stride(input logic [WB-1:0] start,
                                               input logic [WB-1:0] step);
    logic [LB-1:0] ln;
    for (int j = 0; j < NW; j++) ln[j*WB +: WB] = start + step * WB'(j);
    return ln;
  endfunction

  function automatic logic [LB-1:0] mk_alt(input logic [WB-1:0] start,
                                            input logic [WB-1:0] amp);
    logic [LB-1:0] ln;
    for (int j = 0; j < NW; j++) ln[j*WB +: WB] = start + ((j % 2) ? amp : '0);
    return ln;
  endfunction

  function automatic logic [LB-1:0] mk_rand();
    logic [LB-1:0] ln;
    for (int j = 0; j < NW; j++) ln[j*WB +: WB] = $urandom;
    return ln;
  endfunction

  // back-pressure driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      out_ready = throttle ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    item_t e;
    item_t prev;
    bit    stalled = 1'b0;
    bit    fin_hs  = 1'b0;
    prev = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stalled) begin
          chk(out_valid && out_plane == prev.plane && out_idx == prev.idx &&
              out_zero == prev.zero && out_base == prev.base, "R9", "stall hold",
              {out_idx, out_plane}, {prev.idx, prev.plane});
        end
        if (fin_hs) chk(in_ready, "R8", "ready after last", in_ready, 1);
        if (out_valid) chk(!in_ready, "R8", "ready while busy", in_ready, 0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected plane", out_idx, 0);
          end else begin
            e = exp_q.pop_front();
            chk(out_idx == e.idx, "R4", "index order", out_idx, e.idx);
            chk(out_base == e.base, "R2 R10", "base", out_base, e.base);
            chk(out_plane == e.plane, "R3 R5 R10", "plane", out_plane, e.plane);
            chk(out_zero == e.zero, "R6", "zero flag", out_zero, e.zero);
            chk(out_last == e.last, "R7", "last flag", out_last, e.last);
          end
        end
        stalled = out_valid && !out_ready;
        fin_hs  = out_valid && out_ready && out_last;
        prev    = '{base: out_base, plane: out_plane, zero: out_zero,
                    idx: out_idx, last: out_last};
      end
    end
  end

  // watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [LB-1:0] ln;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_line  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid, "R1", "valid in reset", out_valid, 0);
    chk(in_ready, "R1", "ready in reset", in_ready, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", "idle after reset",
        {out_valid, in_ready}, 2'b01);

    // R3 R5: constant stride, then wrapping descent
    send_line(mk_stride(32'd100, 32'd3), 1'b0);
    send_line(mk_stride(32'd5, 32'hFFFF_FFF9), 1'b0);
    // R5: alternating-sign steps
    send_line(mk_alt(32'd1000, 32'd5), 1'b0);
    // R6: all-zero line
    send_line('0, 1'b0);
    send_line({LB{1'b1}}, 1'b0);
    // single outlier word
    ln = mk_stride(32'h0001_0000, 32'd4);
    ln[17*WB +: WB] = ln[17*WB +: WB] ^ 32'h8000_0000;
    send_line(ln, 1'b0);
    // R9: throttled output, R10: offers while busy
    throttle = 1'b1;
    send_line(mk_rand(), 1'b1);
    send_line(mk_rand(), 1'b0);
    send_line(mk_alt(32'hFFFF_FFF0, 32'h0000_0020), 1'b1);
    send_line(mk_rand(), 1'b0);

    while (exp_q.size() != 0) @(negedge clk);
    throttle = 1'b0;
    repeat (4) @(negedge clk);
    chk(!out_valid && in_ready, "R8", "idle at end", {out_valid, in_ready}, 2'b01);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule